// File: doc/BRIEF.md
# Interrupt Controller Countdown Timer

This block is the countdown timer of a per-processor interrupt controller. Software reaches it through a word-wide register port with four registers. An initial-count register starts the timer. A read-only register shows the count as it runs. A divide-configuration register sets the rate. A vector-table entry holds the interrupt vector, a mask bit and a mode bit.

The bus clock passes through a prescaler with eight ratios, from 1 to 128, and then drives a down-counter. When the counter runs out, the block sends a one-cycle interrupt request that carries the programmed vector. The mask bit suppresses that request. In periodic mode the counter starts again from the initial count. In one-shot mode it stops at zero.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the entry register reads 0x00010000 (masked, one-shot, vector 0). The initial-count, current-count and divide registers read 0. Unmapped addresses read 0.
- R2: The entry register at byte address 0x320 keeps bits 7:0 (vector), bit 16 (mask) and bit 17 (mode, 1 = periodic), and reads its other bits as 0. The divide register at 0x3E0 keeps bits 3:0. The initial-count register at 0x380 keeps all 32 bits.
- R3: The divide ratio comes from divide-register bits {3,1,0}. The values 000, 001, 010, 011, 100, 101 and 110 give ratios 2, 4, 8, 16, 32, 64 and 128. The value 111 gives a ratio of 1. Bit 2 has no effect.
- R4: A nonzero write N to the initial count loads the counter and restarts the prescaler. k×ratio cycles after the write edge, the current-count register at 0x390 reads N−k. This is true even if the timer was already running.
- R5: When the count runs out, irq_valid is high for exactly one cycle, N×ratio cycles after the write edge. In that cycle irq_vector equals the entry vector.
- R6: In periodic mode the counter reloads N at expiry without passing through zero, and a request follows every N×ratio cycles.
- R7: In one-shot mode the counter stays at 0 after expiry. No further request comes until the initial count is written again.
- R8: While the mask bit is set, the counter runs and reloads as usual, but irq_valid stays low.
- R9: Writing 0 to the initial count stops the timer. The current count reads 0 and no request follows.
- R10: Writes to the current-count address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the timer's base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The bench samples the current count and the request on every cycle after each start. A prescaler that failed to restart on a load, or that was off by one, would shift the decrements and the request by some cycles. Aliased divide codes, with bit 2 set, check that bit 2 is ignored; a decoder that used it would pick the wrong ratio. A count of 1 with a ratio of 1 in periodic mode needs a request on every cycle. A design that put a zero state between reloads would skip every other request. Rewrites during a run, zero writes, masked runs and one-shot runs catch stray requests and counts that fail to hold.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned PRE_W  = 7;   // widest prescale ratio is 2**PRE_W
  localparam logic [ADDR_W-1:0] OFS_ENTRY = 12'h320;
  localparam logic [ADDR_W-1:0] OFS_INIT  = 12'h380;
  localparam logic [ADDR_W-1:0] OFS_CUR   = 12'h390;
  localparam logic [ADDR_W-1:0] OFS_DIV   = 12'h3E0;
  localparam int unsigned BIT_MASK = 16;
  localparam int unsigned BIT_MODE = 17;

  typedef struct packed {
    logic       periodic;
    logic       mask;
    logic [7:0] vec;
  } entry_t;

  // Divide code -> log2 of the ratio; bit 2 is a don't-care.
  function automatic logic [2:0] div_shift(input logic [3:0] code);
    logic [2:0] idx;
    casez (code)
      4'b0?00: idx = 3'd0;
      4'b0?01: idx = 3'd1;
      4'b0?10: idx = 3'd2;
      4'b0?11: idx = 3'd3;
      4'b1?00: idx = 3'd4;
      4'b1?01: idx = 3'd5;
      4'b1?10: idx = 3'd6;
      default: idx = 3'd7;
    endcase
    return idx + 3'd1;  // 7 wraps to 0: ratio 1
  endfunction

  // Terminal prescale value for a given shift.
  function automatic logic [PRE_W-1:0] div_last(input logic [2:0] sh);
    return PRE_W'((32'd1 << sh) - 32'd1);
  endfunction
endpackage

// File: rtl/irqtmr_regs.sv
module irqtmr_regs
  import irqtmr_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CW-1:0]     cur_count,
  output logic [31:0]       rdata,
  output entry_t            entry,
  output logic [CW-1:0]     init_q,
  output logic [3:0]        div_code,
  output logic              load_wr,
  output logic [CW-1:0]     load_val
);
  assign load_wr  = wr_en && (addr == OFS_INIT);
  assign load_val = wdata[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry    <= '{periodic: 1'b0, mask: 1'b1, vec: 8'h00};
      init_q   <= '0;
      div_code <= 4'h0;
    end else if (wr_en) begin
      case (addr)
        OFS_ENTRY: entry <= '{periodic: wdata[BIT_MODE], mask: wdata[BIT_MASK], vec: wdata[7:0]};
        OFS_INIT:  init_q <= load_val;
        OFS_DIV:   div_code <= wdata[3:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_ENTRY: begin
        rdata[7:0]      = entry.vec;
        rdata[BIT_MASK] = entry.mask;
        rdata[BIT_MODE] = entry.periodic;
      end
      OFS_INIT: rdata = 32'(init_q);
      OFS_CUR:  rdata = 32'(cur_count);
      OFS_DIV:  rdata = {28'd0, div_code};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqtmr_prescale.sv
module irqtmr_prescale
  import irqtmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       enable,
  input  logic [3:0] div_code,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last;

  assign last = div_last(div_shift(div_code));
  // >= keeps the tick alive if the ratio shrinks mid-period.
  assign tick = enable && (pre_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)                         pre_q <= '0;
    else if (restart || !enable || tick) pre_q <= '0;
    else                                pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/irqtmr_down.sv
module irqtmr_down
  import irqtmr_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_wr,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] reload_val,
  input  logic          tick,
  input  entry_t        entry,
  output logic [CW-1:0] count,
  output logic          running,
  output logic          expire,
  output logic          irq_valid,
  output logic [7:0]    irq_vector
);
  assign expire = running && tick && (count == CW'(1)) && !load_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (load_wr) begin
      count   <= load_val;
      running <= (load_val != '0);
    end else if (expire) begin
      if (entry.periodic) begin
        count <= reload_val;
      end else begin
        count   <= '0;
        running <= 1'b0;
      end
    end else if (running && tick) begin
      count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= 8'h00;
    end else begin
      irq_valid <= expire && !entry.mask;
      if (expire) irq_vector <= entry.vec;
    end
  end
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import irqtmr_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_valid,
  output logic [7:0]        irq_vector
);
  entry_t        entry;
  logic [CW-1:0] init_q;
  logic [CW-1:0] load_val;
  logic [CW-1:0] count;
  logic [3:0]    div_code;
  logic          load_wr;
  logic          tick;
  logic          running;
  logic          expire;

  irqtmr_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cur_count(count), .rdata(bus_rdata), .entry(entry), .init_q(init_q),
    .div_code(div_code), .load_wr(load_wr), .load_val(load_val)
  );

  irqtmr_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load_wr), .enable(running),
    .div_code(div_code), .tick(tick)
  );

  irqtmr_down #(.CW(CW)) u_down (
    .clk(clk), .rst_n(rst_n), .load_wr(load_wr), .load_val(load_val),
    .reload_val(init_q), .tick(tick), .entry(entry), .count(count),
    .running(running), .expire(expire), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );
endmodule

// File: rtl/irqtmr_chk.sv
module irqtmr_chk
  import irqtmr_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_wr,
  input logic          tick,
  input logic          running,
  input logic          expire,
  input logic [CW-1:0] count,
  input logic [CW-1:0] init_q,
  input entry_t        entry,
  input logic          irq_valid,
  input logic [7:0]    irq_vector
);
  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(expire));
  // R5
  vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == $past(entry.vec)));
  // R8
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && entry.mask) |=> !irq_valid);
  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && count > CW'(1) && !load_wr) |=> (count == $past(count) - CW'(1)));
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !load_wr) |=> $stable(count));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && entry.periodic) |=> (count == $past(init_q)));
  // R7
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load_wr) |=> ($stable(count) && !running));
endmodule

bind irq_countdown_timer irqtmr_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_wr(load_wr), .tick(tick), .running(running),
  .expire(expire), .count(count), .init_q(init_q), .entry(entry),
  .irq_valid(irq_valid), .irq_vector(irq_vector)
);

// File: tb/irq_countdown_timer_test.sv
module irq_countdown_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = 12'h000;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [11:0] A_ENT = 12'h320, A_INI = 12'h380, A_CUR = 12'h390, A_DIV = 12'h3E0;

  irq_countdown_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic int ratio_of(input logic [3:0] code);
    case (code)
      4'h0, 4'h4: return 2;
      4'h1, 4'h5: return 4;
      4'h2, 4'h6: return 8;
      4'h3, 4'h7: return 16;
      4'h8, 4'hC: return 32;
      4'h9, 4'hD: return 64;
      4'hA, 4'hE: return 128;
      default:    return 1;
    endcase
  endfunction

  function automatic int exp_count(input int c, input int n, input int r, input bit per);
    int k;
    k = c / r;
    if (per) return n - (k % n);
    return (k >= n) ? 0 : n - k;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Program and start; watch every cycle of two periods.
  task automatic run_scn(input logic [3:0] code, input int n, input bit per, input bit msk, input logic [7:0] vec);
    int r, t;
    bit exp_p;
    r = ratio_of(code);
    t = n * r;
    wr(A_ENT, {14'd0, per, msk, 8'd0, vec});
    wr(A_DIV, {28'd0, code});
    wr(A_INI, n);
    bus_addr = A_CUR;
    for (int c = 1; c <= 2 * t + 3; c++) begin
      @(negedge clk);
      exp_p = !msk && (per ? (c % t == 0) : (c == t));
      check(irq_valid == exp_p, per ? (msk ? "R8 periodic pulse" : "R6 periodic pulse")
                                    : (msk ? "R8 one-shot pulse" : "R5/R7 one-shot pulse"),
            irq_valid, exp_p);
      if (exp_p) check(irq_vector == vec, "R5 vector", irq_vector, vec);
      check(bus_rdata == exp_count(c, n, r, per), "R4 current count", bus_rdata, exp_count(c, n, r, per));
    end
  endtask

  task automatic stop_and_check();
    wr(A_INI, 32'd0);
    bus_addr = A_CUR;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      check(bus_rdata == 0, "R9 stopped count", bus_rdata, 0);
      check(irq_valid == 1'b0, "R9 no pulse after stop", irq_valid, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_ENT, d); check(d == 32'h0001_0000, "R1 entry reset", d, 32'h0001_0000);
    rd(A_INI, d); check(d == 0, "R1 init reset", d, 0);
    rd(A_CUR, d); check(d == 0, "R1 count reset", d, 0);
    rd(A_DIV, d); check(d == 0, "R1 divide reset", d, 0);
    rd(12'h100, d); check(d == 0, "R1 unmapped read", d, 0);
    check(irq_valid == 1'b0, "R1 no request after reset", irq_valid, 0);

    // R2 readback masks
    wr(A_ENT, 32'hFFFF_FFFF); rd(A_ENT, d); check(d == 32'h0003_00FF, "R2 entry readback", d, 32'h0003_00FF);
    wr(A_DIV, 32'hFFFF_FFFF); rd(A_DIV, d); check(d == 32'h0000_000F, "R2 divide readback", d, 32'hF);
    wr(A_ENT, 32'h0001_0000);
    wr(A_INI, 32'hDEAD_BEEF); rd(A_INI, d); check(d == 32'hDEAD_BEEF, "R2 init readback", d, 32'hDEAD_BEEF);
    stop_and_check();

    // R3 directed ratios including aliased codes
    run_scn(4'hB, 1, 1'b1, 1'b0, 8'h21);   // ratio 1, pulse every cycle
    run_scn(4'hF, 3, 1'b0, 1'b0, 8'h22);   // R3 bit 2 ignored -> ratio 1
    run_scn(4'h4, 3, 1'b1, 1'b0, 8'h23);   // R3 bit 2 ignored -> ratio 2
    run_scn(4'hA, 2, 1'b0, 1'b0, 8'h24);   // ratio 128
    stop_and_check();

    // R10 write to current count ignored
    run_scn(4'h0, 2, 1'b0, 1'b0, 8'h31);
    wr(A_CUR, 32'h55);
    rd(A_CUR, d); check(d == 0, "R10 current count write ignored", d, 0);
    check(irq_valid == 1'b0, "R10 no pulse from count write", irq_valid, 0);

    // R4 rewrite while running restarts from the new count
    wr(A_ENT, 32'h0002_0040); wr(A_DIV, 32'hB); wr(A_INI, 9);
    repeat (4) @(negedge clk);
    run_scn(4'h1, 3, 1'b1, 1'b0, 8'h41);
    // R9 stop in mid-count
    stop_and_check();

    // R8 masked periodic run
    run_scn(4'h0, 4, 1'b1, 1'b1, 8'h51);
    stop_and_check();

    // Random mix
    for (int i = 0; i < 24; i++) begin
      run_scn(4'($urandom % 16), 1 + int'($urandom % 5), 1'($urandom % 2),
              ($urandom % 4) == 0, 8'($urandom));
      if (i % 6 == 5) stop_and_check();
    end
    stop_and_check();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule